// File: doc/BRIEF.md
# Accumulator CPU with Shared Bus

This block is a small 8-bit processor built around one shared data bus. A bus multiplexer selects exactly one source per cycle: the program counter, the RAM read port, the low argument bits of the instruction register, register A, register B or the ALU. The chosen value is latched by whichever destinations the sequencer enables. Program and data share a 32-byte internal RAM. Every instruction takes the same six clock cycles: two fetch steps, then four execute steps. Some execute steps are idle, depending on the opcode.

Each instruction byte carries a 3-bit opcode in bits 7:5 and a 5-bit argument X in bits 4:0. The eight operations are:

- load A from RAM[X];
- load A with the immediate X;
- store A to RAM[X];
- swap A and B using RAM[X] as scratch;
- jump to X;
- jump to X when the zero flag is set;
- add RAM[X] to A;
- subtract RAM[X] from A.

While reset is held, an external write port fills the RAM. After reset is released, execution starts at address 0. The values of A, B, the program counter and the zero flag are brought out on debug outputs so that a bench can observe them.

Top module: `acc_cpu`

## Requirements
- R1: Every instruction occupies exactly six clock cycles. The program counter increments by one on the second cycle of each instruction. From reset release, the PC therefore reads 1 after 7 cycles, 2 after 8 cycles and N after 6N cycles when no jump occurs.
- R2: Opcode 001 loads A with the argument bits 4:0 zero-extended to 8 bits. For example, byte 0x3F gives A = 0x1F.
- R3: Opcode 000 loads A from RAM[X], and opcode 010 writes A into RAM[X].
- R4: Opcode 110 first copies RAM[X] into B, then sets A to (A + B) mod 256.
- R5: Opcode 111 first copies RAM[X] into B, then sets A to (A - B) mod 256.
- R6: The zero flag is written only by opcodes 110 and 111, and it is set exactly when their 8-bit result is zero. All other opcodes leave the flag unchanged.
- R7: Opcode 011 exchanges A and B and leaves the old value of A in RAM[X].
- R8: Opcode 100 loads the PC with X.
- R9: Opcode 101 loads the PC with X when the zero flag is 1. When the flag is 0, the PC keeps the incremented value from the fetch.
- R10: A synchronous active-high reset clears A, B, the PC, the zero flag and the step counter. It leaves the RAM contents unchanged.
- R11: The load port (`load_we`, `load_addr`, `load_data`) writes the RAM only while reset is high. Writes attempted while the CPU runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| load_we | input | 1 | RAM preload write enable (effective only in reset) |
| load_addr | input | 5 | RAM preload address |
| load_data | input | 8 | RAM preload data |
| dbg_a | output | 8 | Current value of register A |
| dbg_b | output | 8 | Current value of register B |
| dbg_pc | output | 5 | Current program counter |
| dbg_zero | output | 1 | Current zero flag |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Arithmetic wrap-around in both directions.** 0x1F + 0xF0 gives 0x0F, and 1 - 2 gives 0xFF. A design that keeps a ninth bit, or that computes B - A instead of A - B, returns a different value.
- **Zero flag set by subtract, then preserved.** The flag is set by a subtract to zero. An immediate load that follows must not change it, and a later conditional jump must then be taken. A design that refreshes the flag on every write to A takes the wrong branch.
- **Swap through the scratch byte.** The test reads RAM[X] back after the swap. A design that swaps A and B directly, or that stores the wrong value, is caught by this read.
- **Timing and memory protection.** The program counter is sampled in the middle of an instruction, which catches a sequencer with the wrong step count. A RAM write attempted while the CPU runs, and data that must survive a reset, catch a load port that is not gated by reset and a reset that clears the memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    parameter int DATA_W  = 8;
    parameter int ADDR_W  = 5;
    parameter int N_STEPS = 6;
    localparam int OP_W   = DATA_W - ADDR_W;
    localparam int STEP_W = $clog2(N_STEPS);

    typedef enum logic [2:0] {
        OP_LDA = 3'b000,
        OP_LDI = 3'b001,
        OP_STA = 3'b010,
        OP_SWP = 3'b011,
        OP_JMP = 3'b100,
        OP_JZ  = 3'b101,
        OP_ADD = 3'b110,
        OP_SUB = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PC,
        SRC_RAM,
        SRC_ARG,
        SRC_A,
        SRC_B,
        SRC_ALU
    } bus_src_e;

    typedef struct packed {
        bus_src_e src;
        logic     a_we;
        logic     b_we;
        logic     mar_we;
        logic     ir_we;
        logic     ram_we;
        logic     pc_inc;
        logic     pc_load;
        logic     flag_we;
        logic     alu_sub;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{src: SRC_NONE, default: 1'b0};

    function automatic logic [DATA_W-1:0] widen_addr(input logic [ADDR_W-1:0] v);
        return {{(DATA_W-ADDR_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int STEPS = N_STEPS
) (
    input  logic                clk,
    input  logic                rst,
    input  opcode_e             opcode,
    input  logic                zero,
    output logic [STEP_W-1:0]   step,
    output ctrl_t               ctl
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (step_q == LAST) begin
            step_q <= '0;
        end else begin
            step_q <= step_q + 1'b1;
        end
    end

    assign step = step_q;

    always_comb begin
        ctl = CTRL_IDLE;
        case (step_q)
            STEP_W'(0): begin
                ctl.src    = SRC_PC;
                ctl.mar_we = 1'b1;
            end
            STEP_W'(1): begin
                ctl.src    = SRC_RAM;
                ctl.ir_we  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            STEP_W'(2): begin
                case (opcode)
                    OP_LDI: begin
                        ctl.src  = SRC_ARG;
                        ctl.a_we = 1'b1;
                    end
                    OP_JMP: begin
                        ctl.src     = SRC_ARG;
                        ctl.pc_load = 1'b1;
                    end
                    OP_JZ: begin
                        ctl.src     = SRC_ARG;
                        ctl.pc_load = zero;
                    end
                    default: begin
                        ctl.src    = SRC_ARG;
                        ctl.mar_we = 1'b1;
                    end
                endcase
            end
            STEP_W'(3): begin
                case (opcode)
                    OP_LDA: begin
                        ctl.src  = SRC_RAM;
                        ctl.a_we = 1'b1;
                    end
                    OP_STA, OP_SWP: begin
                        ctl.src    = SRC_A;
                        ctl.ram_we = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        ctl.src  = SRC_RAM;
                        ctl.b_we = 1'b1;
                    end
                    default: ctl = CTRL_IDLE;
                endcase
            end
            STEP_W'(4): begin
                case (opcode)
                    OP_SWP: begin
                        ctl.src  = SRC_B;
                        ctl.a_we = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        ctl.src     = SRC_ALU;
                        ctl.a_we    = 1'b1;
                        ctl.flag_we = 1'b1;
                        ctl.alu_sub = (opcode == OP_SUB);
                    end
                    default: ctl = CTRL_IDLE;
                endcase
            end
            STEP_W'(5): begin
                if (opcode == OP_SWP) begin
                    ctl.src  = SRC_RAM;
                    ctl.b_we = 1'b1;
                end
            end
            default: ctl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         sub,
    output logic [W-1:0] result,
    output logic         is_zero
);

    always_comb begin
        if (sub) begin
            result = lhs - rhs;
        end else begin
            result = lhs + rhs;
        end
        is_zero = (result == '0);
    end

endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] dbg_a,
    output logic [DW-1:0] dbg_b,
    output logic [AW-1:0] dbg_pc,
    output logic          dbg_zero
);

    logic [DW-1:0]     a_q, b_q, ir_q;
    logic [AW-1:0]     pc_q, mar_q;
    logic              zero_q;
    logic [DW-1:0]     bus;
    logic [DW-1:0]     ram_rdata, alu_y;
    logic              alu_z;
    logic [STEP_W-1:0] step;
    ctrl_t             ctl;
    opcode_e           opcode;

    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [DW-1:0]     ram_wdata;

    assign opcode = opcode_e'(ir_q[DW-1 -: OP_W]);

    acc_cpu_seq #(.STEPS(N_STEPS)) i_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .zero   (zero_q),
        .step   (step),
        .ctl    (ctl)
    );

    acc_cpu_alu #(.W(DW)) i_alu (
        .lhs     (a_q),
        .rhs     (b_q),
        .sub     (ctl.alu_sub),
        .result  (alu_y),
        .is_zero (alu_z)
    );

    always_comb begin
        if (rst) begin
            ram_we    = load_we;
            ram_waddr = load_addr;
            ram_wdata = load_data;
        end else begin
            ram_we    = ctl.ram_we;
            ram_waddr = mar_q;
            ram_wdata = bus;
        end
    end

    acc_cpu_ram #(.DW(DW), .AW(AW)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (mar_q),
        .rdata (ram_rdata)
    );

    always_comb begin
        case (ctl.src)
            SRC_PC:  bus = widen_addr(pc_q);
            SRC_RAM: bus = ram_rdata;
            SRC_ARG: bus = widen_addr(ir_q[AW-1:0]);
            SRC_A:   bus = a_q;
            SRC_B:   bus = b_q;
            SRC_ALU: bus = alu_y;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            pc_q   <= '0;
            mar_q  <= '0;
            ir_q   <= '0;
            zero_q <= 1'b0;
        end else begin
            if (ctl.a_we)    a_q    <= bus;
            if (ctl.b_we)    b_q    <= bus;
            if (ctl.mar_we)  mar_q  <= bus[AW-1:0];
            if (ctl.ir_we)   ir_q   <= bus;
            if (ctl.flag_we) zero_q <= alu_z;
            if (ctl.pc_load) begin
                pc_q <= bus[AW-1:0];
            end else if (ctl.pc_inc) begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    assign dbg_a    = a_q;
    assign dbg_b    = b_q;
    assign dbg_pc   = pc_q;
    assign dbg_zero = zero_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] step,
    input logic [7:0] ir,
    input logic [4:0] pc,
    input logic [7:0] a,
    input logic [7:0] b,
    input logic       zero,
    input logic       flag_we
);

    // R1: the step counter advances by one and wraps after the sixth step
    a_r1_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd5) |=> (step == 3'd0));

    a_r1_step_inc: assert property (@(posedge clk) disable iff (rst)
        (step < 3'd5) |=> (step == $past(step) + 3'd1));

    // R1: the PC moves only on the fetch step or the jump step
    a_r1_pc_quiet: assert property (@(posedge clk) disable iff (rst)
        (step != 3'd1 && step != 3'd2) |=> $stable(pc));

    // R2: the immediate load yields the zero-extended argument
    a_r2_imm_load: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd2 && ir[7:5] == 3'b001) |=> (a == {3'b000, $past(ir[4:0])}));

    // R6: the flag holds unless an arithmetic result step writes it
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(zero));

    // R8: an unconditional jump lands on the argument
    a_r8_jump: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd2 && ir[7:5] == 3'b100) |=> (pc == $past(ir[4:0])));

    // R10: reset clears the architectural state
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (a == 8'd0 && b == 8'd0 && pc == 5'd0 && !zero && step == 3'd0));

endmodule

bind acc_cpu acc_cpu_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .ir      (ir_q),
    .pc      (pc_q),
    .a       (a_q),
    .b       (b_q),
    .zero    (zero_q),
    .flag_we (ctl.flag_we)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_we = 1'b0;
    logic [4:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [7:0] dbg_a, dbg_b;
    logic [4:0] dbg_pc;
    logic       dbg_zero;

    int n_checks = 0;
    int n_fails  = 0;

    acc_cpu i_acc_cpu (
        .clk       (clk),
        .rst       (rst),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .dbg_a     (dbg_a),
        .dbg_b     (dbg_b),
        .dbg_pc    (dbg_pc),
        .dbg_zero  (dbg_zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic poke(input logic [4:0] addr, input logic [7:0] data);
        load_we   = 1'b1;
        load_addr = addr;
        load_data = data;
        @(negedge clk);
        load_we   = 1'b0;
    endtask

    task automatic release_reset();
        rst = 1'b0;
    endtask

    task automatic run_cycles(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        enter_reset();
        check("R10", "A after reset", dbg_a, 0);
        check("R10", "B after reset", dbg_b, 0);
        check("R10", "PC after reset", dbg_pc, 0);
        check("R10", "flag after reset", dbg_zero, 0);
    endtask

    task automatic t_load_store();
        enter_reset();
        poke(5'd0, 8'h3F);
        poke(5'd1, 8'h54);
        poke(5'd2, 8'h23);
        poke(5'd3, 8'h14);
        release_reset();
        run_cycles(7);
        check("R1", "PC after 7 cycles", dbg_pc, 1);
        run_cycles(1);
        check("R1", "PC after 8 cycles", dbg_pc, 2);
        run_cycles(4);
        check("R2", "A zero-extended immediate", dbg_a, 8'h1F);
        check("R1", "PC after 12 cycles", dbg_pc, 2);
        run_cycles(6);
        check("R2", "A after second immediate", dbg_a, 8'h03);
        run_cycles(6);
        check("R3", "A reloaded from stored byte", dbg_a, 8'h1F);
        check("R1", "PC after four instructions", dbg_pc, 4);
        check("R6", "flag untouched by loads/stores", dbg_zero, 0);
    endtask

    task automatic t_reset_keeps_ram();
        t_reset_state();
        poke(5'd0, 8'h14);
        release_reset();
        run_cycles(6);
        check("R10", "RAM byte survives reset", dbg_a, 8'h1F);
    endtask

    task automatic t_arith();
        enter_reset();
        poke(5'd0, 8'h3F);
        poke(5'd1, 8'hDE);
        poke(5'd2, 8'hFD);
        poke(5'd3, 8'h21);
        poke(5'd4, 8'hFC);
        poke(5'd30, 8'hF0);
        poke(5'd29, 8'h0F);
        poke(5'd28, 8'h02);
        release_reset();
        run_cycles(12);
        check("R4", "add wraps", dbg_a, 8'h0F);
        check("R4", "B holds add operand", dbg_b, 8'hF0);
        check("R6", "flag clear on nonzero sum", dbg_zero, 0);
        run_cycles(6);
        check("R5", "subtract to zero", dbg_a, 8'h00);
        check("R5", "B holds sub operand", dbg_b, 8'h0F);
        check("R6", "flag set on zero result", dbg_zero, 1);
        run_cycles(12);
        check("R5", "subtract wraps below zero", dbg_a, 8'hFF);
        check("R6", "flag clear after 1-2", dbg_zero, 0);
    endtask

    task automatic t_swap();
        enter_reset();
        poke(5'd0, 8'h25);
        poke(5'd1, 8'hDB);
        poke(5'd2, 8'h7C);
        poke(5'd3, 8'h1C);
        poke(5'd27, 8'h80);
        poke(5'd28, 8'h11);
        release_reset();
        run_cycles(12);
        check("R4", "A before swap", dbg_a, 8'h85);
        run_cycles(6);
        check("R7", "A after swap", dbg_a, 8'h80);
        check("R7", "B after swap", dbg_b, 8'h85);
        check("R6", "flag unchanged by swap", dbg_zero, 0);
        run_cycles(6);
        check("R7", "scratch byte holds old A", dbg_a, 8'h85);
    endtask

    task automatic t_jump();
        enter_reset();
        poke(5'd0, 8'h8A);
        poke(5'd10, 8'h27);
        release_reset();
        run_cycles(6);
        check("R8", "PC after jump", dbg_pc, 10);
        run_cycles(6);
        check("R8", "instruction at target ran", dbg_a, 8'h07);
        check("R8", "PC after target", dbg_pc, 11);
    endtask

    task automatic t_cond_jump();
        enter_reset();
        poke(5'd0, 8'h21);
        poke(5'd1, 8'hF9);
        poke(5'd2, 8'h29);
        poke(5'd3, 8'hAC);
        poke(5'd12, 8'h22);
        poke(5'd13, 8'hD9);
        poke(5'd14, 8'hA0);
        poke(5'd25, 8'h01);
        release_reset();
        run_cycles(12);
        check("R6", "flag set by 1-1", dbg_zero, 1);
        run_cycles(6);
        check("R6", "flag kept over immediate load", dbg_zero, 1);
        check("R2", "A after immediate", dbg_a, 8'h09);
        run_cycles(6);
        check("R9", "taken conditional jump", dbg_pc, 12);
        run_cycles(12);
        check("R4", "A after 2+1", dbg_a, 8'h03);
        check("R6", "flag cleared by nonzero sum", dbg_zero, 0);
        run_cycles(6);
        check("R9", "untaken conditional jump", dbg_pc, 15);
    endtask

    task automatic t_load_port_gated();
        enter_reset();
        poke(5'd0, 8'h20);
        poke(5'd1, 8'h20);
        poke(5'd2, 8'h20);
        poke(5'd3, 8'h14);
        poke(5'd20, 8'h44);
        release_reset();
        run_cycles(3);
        load_we   = 1'b1;
        load_addr = 5'd20;
        load_data = 8'h99;
        run_cycles(1);
        load_we   = 1'b0;
        run_cycles(20);
        check("R11", "load port ignored while running", dbg_a, 8'h44);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        t_load_store();
        t_reset_keeps_ram();
        t_arith();
        t_swap();
        t_jump();
        t_cond_jump();
        t_load_port_gated();
        summary();
        $finish;
    end

endmodule